// File: doc/BRIEF.md
# Four-Mode Addressable Bit Store

This block keeps an eight-bit word of single-bit flags that are written one bit at a time. A three-bit address picks one bit, a single data input gives its new value, and two active-low control inputs choose what happens in each cycle. The four choices are:

- write the addressed bit;
- leave all bits as they are;
- route the data input to the addressed output while every other output is held low;
- force all outputs low and clear the stored word.

The design is synchronous. A register holds the stored word and changes only on the rising clock edge. Combinational output logic chooses, from the current mode, between the stored word, a demultiplexed copy of the data input, or zero.

The mode is decoded fresh each cycle from the two control inputs. There are four named mode states: WRITE, KEEP, ROUTE and WIPE. Any mode can follow any other. The transitions that matter are these:

- KEEP→WRITE→KEEP: a single-bit update.
- KEEP→ROUTE→KEEP: the stored word shows again unchanged after routing.
- any→WIPE: the outputs drop at once and the word is cleared at the next edge.

A separate asynchronous power-on reset clears the stored word.

The block is used for scattered control flags or as a small one-hot strobe generator. The address should be moved only while in KEEP. Moving it in WRITE can write the wrong bit.

Top module: `addr_latch_demux`

## Requirements
- R1: Mode selection from (wr_en_n, wipe_n): (0,1) is WRITE, (1,1) is KEEP, (0,0) is ROUTE, (1,0) is WIPE.
- R2: In WRITE, the bit chosen by sel is loaded from din on the rising edge. It appears on q from that edge on, while the other bits keep their values. During the WRITE cycle itself, q shows the word stored before the edge.
- R3: sel is binary with sel[0] as its least significant bit: value k selects q[k] (0 selects q[0], 7 selects q[7]).
- R4: In KEEP, q equals the stored word, and changes on sel and din have no effect on q or on the stored word.
- R5: In ROUTE, q[sel] equals din combinationally in the same cycle and every other bit of q is 0.
- R6: ROUTE does not alter the stored word. On return to KEEP, q shows the word stored before ROUTE was entered.
- R7: In WIPE, q is 0 in the same cycle whatever sel and din are, and the stored word is cleared at the next rising edge. A later KEEP cycle therefore shows 0.
- R8: While por_n is low, the stored word is cleared asynchronously, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| wr_en_n | input | 1 | Active-low enable; with wipe_n it selects the mode |
| wipe_n | input | 1 | Active-low functional clear; with wr_en_n it selects the mode |
| sel | input | AW (3) | Binary bit address, sel[0] least significant |
| din | input | 1 | Data bit to write or to route |
| q | output | 2**AW (8) | Output word |

## Verification
The two kinds of result are due at different times:

- ROUTE and WIPE outputs are combinational and are due in the same cycle as the inputs that cause them.
- A WRITE changes q only after the next rising edge, so the written bit is due one cycle later.
- The asynchronous clear acts at once, in the middle of a cycle.

The driver applies inputs on the falling edge and computes the expected q for that same cycle from a model of the stored word. It advances the model for the following edge only after that. The monitor compares one time unit after the falling edge, well clear of the rising edge, so same-cycle and next-cycle results are both caught at a stable point.

// File: rtl/alx_pkg.sv
package alx_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_KEEP  = 2'd1,
        MODE_ROUTE = 2'd2,
        MODE_WIPE  = 2'd3
    } alx_mode_e;

endpackage

// File: rtl/alx_mode_dec.sv
module alx_mode_dec
    import alx_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      wipe_n,
    output alx_mode_e mode
);

    always_comb begin
        unique case ({wr_en_n, wipe_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_KEEP;
            2'b00:   mode = MODE_ROUTE;
            default: mode = MODE_WIPE;
        endcase
    end

endmodule

// File: rtl/alx_onehot.sv
module alx_onehot #(
    parameter int AW = 3,
    localparam int N = 1 << AW
) (
    input  logic [AW-1:0] sel,
    output logic [N-1:0]  hot
);

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hot[i] = (sel == AW'(i));
    end

endmodule

// File: rtl/alx_store.sv
module alx_store
    import alx_pkg::*;
#(
    parameter int AW = 3,
    localparam int N = 1 << AW
) (
    input  logic      clk,
    input  logic      por_n,
    input  alx_mode_e mode,
    input  logic [N-1:0] hot,
    input  logic      din,
    output logic [N-1:0] word
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic nxt;

        always_comb begin
            unique case (mode)
                MODE_WRITE: nxt = hot[i] ? din : word[i];
                MODE_WIPE:  nxt = 1'b0;
                MODE_KEEP,
                MODE_ROUTE: nxt = word[i];
                default:    nxt = word[i];
            endcase
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                word[i] <= 1'b0;
            end else begin
                word[i] <= nxt;
            end
        end
    end

endmodule

// File: rtl/alx_outsel.sv
module alx_outsel
    import alx_pkg::*;
#(
    parameter int AW = 3,
    localparam int N = 1 << AW
) (
    input  alx_mode_e    mode,
    input  logic [N-1:0] word,
    input  logic [N-1:0] hot,
    input  logic         din,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_out
        always_comb begin
            unique case (mode)
                MODE_WRITE,
                MODE_KEEP:  q[i] = word[i];
                MODE_ROUTE: q[i] = hot[i] & din;
                MODE_WIPE:  q[i] = 1'b0;
                default:    q[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux #(
    parameter int AW = 3,
    localparam int N = 1 << AW
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wr_en_n,
    input  logic          wipe_n,
    input  logic [AW-1:0] sel,
    input  logic          din,
    output logic [N-1:0]  q
);

    alx_pkg::alx_mode_e mode;
    logic [N-1:0]       hot;
    logic [N-1:0]       word;

    alx_mode_dec u_mode (
        .wr_en_n (wr_en_n),
        .wipe_n  (wipe_n),
        .mode    (mode)
    );

    alx_onehot #(.AW(AW)) u_dec (
        .sel (sel),
        .hot (hot)
    );

    alx_store #(.AW(AW)) u_store (
        .clk   (clk),
        .por_n (por_n),
        .mode  (mode),
        .hot   (hot),
        .din   (din),
        .word  (word)
    );

    alx_outsel #(.AW(AW)) u_out (
        .mode (mode),
        .word (word),
        .hot  (hot),
        .din  (din),
        .q    (q)
    );

endmodule

// File: rtl/alx_chk.sv
module alx_chk #(
    parameter int AW = 3,
    localparam int N = 1 << AW
) (
    input logic          clk,
    input logic          por_n,
    input logic          wr_en_n,
    input logic          wipe_n,
    input logic [AW-1:0] sel,
    input logic          din,
    input logic [N-1:0]  q
);

    // R5
    route_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en_n && !wipe_n) |-> ($onehot0(q) && (q[sel] == din)));

    // R7
    wipe_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en_n && !wipe_n) |-> (q == '0));

    // R7
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && $past(wr_en_n && !wipe_n) && wipe_n) |-> (q == '0));

    // R4
    keep_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && $past(wr_en_n && wipe_n) && wr_en_n && wipe_n) |-> $stable(q));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && $past(!wr_en_n && wipe_n) && wipe_n) |-> (q[$past(sel)] == $past(din)));

endmodule

bind addr_latch_demux alx_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en_n (wr_en_n),
    .wipe_n  (wipe_n),
    .sel     (sel),
    .din     (din),
    .q       (q)
);

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       wipe_n = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic [7:0] q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    addr_latch_demux dut (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en_n (wr_en_n),
        .wipe_n  (wipe_n),
        .sel     (sel),
        .din     (din),
        .q       (q)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s q=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply inputs, push the same-cycle expectation, then advance the model.
    task automatic step(input logic e, input logic c, input logic [2:0] a,
                        input logic d, input string tag);
        item_t it;
        @(negedge clk);
        wr_en_n = e; wipe_n = c; sel = a; din = d;
        unique case ({e, c})
            2'b01: begin it.exp = model; model[a] = d; end
            2'b11: it.exp = model;
            2'b00: begin it.exp = '0; it.exp[a] = d; end
            default: begin it.exp = '0; model = '0; end
        endcase
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic write_bit(input logic [2:0] a, input logic d);
        step(1'b1, 1'b1, a, ~d, "R4");
        step(1'b0, 1'b1, a, d, "R2");
        step(1'b1, 1'b1, a, d, "R2");
    endtask

    // Monitor: compare clear of the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(q, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check(q, 8'h00, "R8 reset state");
        @(negedge clk);
        por_n = 1'b1;

        // R1 R3: write A5 one bit per address
        for (int a = 0; a < 8; a++) write_bit(3'(a), 1'((8'hA5 >> a) & 1));
        step(1'b1, 1'b1, 3'd0, 1'b0, "R3");

        // R4: address and data wiggle in KEEP
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'(i), 1'(i), "R4");

        // R5 R1: full route sweep
        for (int a = 0; a < 8; a++)
            for (int d = 0; d < 2; d++) step(1'b0, 1'b0, 3'(a), 1'(d), "R5");

        // R6: stored word returns
        step(1'b1, 1'b1, 3'd2, 1'b1, "R6");
        step(1'b1, 1'b1, 3'd7, 1'b0, "R6");

        // R2: overwrite bits, repeated writes to one address
        write_bit(3'd3, 1'b1);
        write_bit(3'd0, 1'b0);
        step(1'b1, 1'b1, 3'd6, 1'b1, "R2");
        step(1'b0, 1'b1, 3'd6, 1'b0, "R2");
        step(1'b0, 1'b1, 3'd6, 1'b1, "R2");
        step(1'b0, 1'b1, 3'd6, 1'b0, "R2");
        step(1'b1, 1'b1, 3'd6, 1'b0, "R2");

        // R7: wipe with varying inputs
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), 1'b1, "R7");
        step(1'b1, 1'b1, 3'd5, 1'b1, "R7");

        // R8: asynchronous clear mid-cycle
        write_bit(3'd1, 1'b1);
        write_bit(3'd4, 1'b1);
        @(posedge clk);
        #1;
        wr_en_n = 1'b1; wipe_n = 1'b1;
        por_n = 1'b0;
        model = '0;
        @(negedge clk);
        #1 check(q, 8'h00, "R8 async clear");
        @(negedge clk);
        por_n = 1'b1;
        step(1'b1, 1'b1, 3'd4, 1'b1, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule